// File: doc/BRIEF.md
# Exception Entry Sequencer

This block decides when a small 32-bit core leaves its instruction stream for an exception, and what state the core has on the way in. It watches three sources: a software-interrupt request and an undefined-instruction request raised by the execute stage, and a fast-interrupt line from an external interrupt controller. When one is accepted, the block switches the processor mode, masks interrupts, writes the return address to the link register, hands the old status word to the banked saved-status register, and redirects the program counter to a fixed vector. It also produces the reset state of the core.

The fast-interrupt line is qualified by the fast-interrupt enable. That qualified pending signal is combinational, so it tracks every change of the mask bits at once. It is only acted on at an instruction boundary, which the core marks with `fetch_slot`. The two synchronous requests are accepted in any running cycle. When sources coincide, the fast interrupt wins, then undefined, then software interrupt.

The core is started by raising `core_en`. Every rising edge of that input forces a one-cycle initialisation step before execution begins. It loads supervisor mode, enables normal interrupts, masks fast interrupts, redirects to address 0 and presents the preset stack-pointer values. Status writes from the core, such as a return from an exception, go through a small control port.

Top module: `exc_entry_seq`

## Requirements
- R1: After `rst_n` is released with `core_en` low, `cur_mode` is 0x13, `irq_off` is 0, `fiq_off` is 1, `running` is 0 and `redirect` is 0.
- R2: A rising edge of `core_en`, sampled at a clock edge, gives one cycle with `init_pulse`=1, `redirect`=1, `pc_target`=0, `exc_code`=0 and stack outputs `sp_usr_init`=0x03007F00, `sp_irq_init`=0x03007FA0, `sp_svc_init`=0x03007FE0. Mode and masks are reloaded to the R1 values, and `running` goes to 1 the cycle after. The stack outputs are 0 outside that cycle.
- R3: An accepted software interrupt gives, one cycle later, `redirect`=1, `pc_target`=0x08, `exc_code`=1, `cur_mode`=0x13 and `irq_off`=1, with `fiq_off` unchanged.
- R4: An accepted undefined instruction gives, one cycle later, `redirect`=1, `pc_target`=0x04, `exc_code`=2, `cur_mode`=0x1B and `irq_off`=1, with `fiq_off` unchanged.
- R5: A fast interrupt is accepted only in a running cycle with `fetch_slot`=1 and `fiq_pend`=1. One cycle later it gives `redirect`=1, `pc_target`=0x1C, `exc_code`=3, `cur_mode`=0x11, `irq_off`=1 and `fiq_off`=1.
- R6: With every accepted exception, `link_we`=1 and `link_val` equals the `next_pc` of the accepting cycle plus 4, modulo 2^32.
- R7: With every accepted exception, `saved_we`=1 and `saved_psr` holds the status before entry. Bit 7 is `irq_off`, bit 6 is `fiq_off`, bit 5 is 0, bits 4:0 are the mode, and bits 31:8 are 0.
- R8: `fiq_pend` equals `fiq_req` AND NOT `fiq_off` in the same cycle, including right after a mask change.
- R9: When sources coincide, the fast interrupt beats undefined and undefined beats software interrupt. Exactly one exception is accepted.
- R10: In a running cycle with no accepted exception, `ctl_we`=1 loads `ctl_mode`, `ctl_irq_off` and `ctl_fiq_off` into `cur_mode`, `irq_off` and `fiq_off` one cycle later. If an exception is accepted in the same cycle, the write is dropped.
- R11: While `core_en` is low or `running` is 0, requests and control writes have no effect: `redirect` stays 0 (apart from R2) and mode and masks are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_en | input | 1 | Core enable; each rising edge starts an initialisation step |
| fetch_slot | input | 1 | Instruction boundary; fast interrupt may be taken |
| swi_req | input | 1 | Software-interrupt request from execute |
| und_req | input | 1 | Undefined-instruction request from execute |
| fiq_req | input | 1 | Fast-interrupt line from the interrupt controller |
| next_pc | input | 32 | Address of the next instruction |
| ctl_we | input | 1 | Status write strobe |
| ctl_mode | input | 5 | Mode to write |
| ctl_irq_off | input | 1 | Normal-interrupt mask to write |
| ctl_fiq_off | input | 1 | Fast-interrupt mask to write |
| running | output | 1 | Core is executing |
| cur_mode | output | 5 | Current processor mode |
| irq_off | output | 1 | Normal interrupts masked |
| fiq_off | output | 1 | Fast interrupts masked |
| fiq_pend | output | 1 | Qualified fast-interrupt pending |
| redirect | output | 1 | Load `pc_target` into the program counter |
| pc_target | output | 32 | New program counter |
| link_we | output | 1 | Write `link_val` to the banked link register |
| link_val | output | 32 | Return address |
| saved_we | output | 1 | Write `saved_psr` to the banked saved-status register |
| saved_psr | output | 32 | Status word before entry |
| exc_code | output | 2 | 0 none/init, 1 software, 2 undefined, 3 fast |
| init_pulse | output | 1 | Initialisation cycle; clear flags and load stack pointers |
| sp_usr_init | output | 32 | Visible stack-pointer reset value |
| sp_irq_init | output | 32 | Interrupt-bank stack-pointer reset value |
| sp_svc_init | output | 32 | Supervisor-bank stack-pointer reset value |

## Verification
The bench sets all three sources together and in pairs. A design with an inverted arbitration order would jump to the software vector while the fast interrupt is waiting. It holds the fast line high with `fetch_slot` low, which catches a design that enters between instructions. It also writes the fast mask clear and then checks `fiq_pend` within the same cycle, which catches a pending signal that is registered and one cycle stale.

Further directed cases cover the following faults:
- A `next_pc` of 0xFFFFFFFC must give a link value of 0; this catches a wrong return offset or a widened adder.
- Requests arriving while disabled must be dropped; this catches a leaky run qualifier.
- Toggling `core_en` must restart the initialisation step; this catches a design that only initialises after reset.
- A control write in the same cycle as an exception must be dropped; this catches a design that lets the write override the entry masks.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int MODE_W = 5;
  localparam int PSR_W  = 32;

  localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;

  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_SWI  = 2'd1,
    EXC_UND  = 2'd2,
    EXC_FIQ  = 2'd3
  } exc_kind_e;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_INIT = 2'd1,
    ST_RUN  = 2'd2
  } run_st_e;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              irq_off;
    logic              fiq_off;
  } core_stat_t;

  // Status right after reset or an initialisation step.
  function automatic core_stat_t boot_stat();
    core_stat_t s;
    s.mode    = MODE_SVC;
    s.irq_off = 1'b0;
    s.fiq_off = 1'b1;
    return s;
  endfunction

  // Status on entry to exception kind k, given the current status.
  function automatic core_stat_t entry_stat(exc_kind_e k, core_stat_t cur);
    core_stat_t s;
    s = cur;
    case (k)
      EXC_SWI: begin s.mode = MODE_SVC; s.irq_off = 1'b1; end
      EXC_UND: begin s.mode = MODE_UND; s.irq_off = 1'b1; end
      EXC_FIQ: begin s.mode = MODE_FIQ; s.irq_off = 1'b1; s.fiq_off = 1'b1; end
      default: s = cur;
    endcase
    return s;
  endfunction

  // Status word layout: [7] irq mask, [6] fiq mask, [5] zero, [4:0] mode.
  function automatic logic [PSR_W-1:0] pack_stat(core_stat_t s);
    logic [PSR_W-1:0] w;
    w = '0;
    w[7]          = s.irq_off;
    w[6]          = s.fiq_off;
    w[MODE_W-1:0] = s.mode;
    return w;
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      active,
  input  logic      fetch_slot,
  input  logic      fiq_pend,
  input  logic      und_req,
  input  logic      swi_req,
  output logic      take,
  output exc_kind_e kind
);

  localparam int N_SRC = 3;

  // Index 0 is the highest priority source.
  logic [N_SRC-1:0] req;
  logic [N_SRC-1:0] grant;

  assign req[0] = active & fetch_slot & fiq_pend;
  assign req[1] = active & und_req;
  assign req[2] = active & swi_req;

  genvar i;
  generate
    for (i = 0; i < N_SRC; i++) begin : g_prio
      if (i == 0) begin : g_top
        assign grant[i] = req[i];
      end else begin : g_low
        assign grant[i] = req[i] & ~(|req[i-1:0]);
      end
    end
  endgenerate

  assign take = |grant;

  always_comb begin
    kind = EXC_NONE;
    if (grant[0])      kind = EXC_FIQ;
    else if (grant[1]) kind = EXC_UND;
    else if (grant[2]) kind = EXC_SWI;
  end

  // R9: at most one source accepted per cycle.
  a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R9: a taken fast interrupt pre-empts every other source.
  a_r9_fiq_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (active && fetch_slot && fiq_pend) |-> (take && kind == EXC_FIQ));

  // R11: nothing is accepted outside a running cycle.
  a_r11_no_take_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !take);

endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       core_en,
  input  logic       take,
  input  exc_kind_e  kind,
  input  logic       ctl_we,
  input  core_stat_t ctl_stat,
  output core_stat_t stat,
  output run_st_e    st,
  output logic       active
);

  logic       en_q;
  logic       en_rise;
  run_st_e    st_nxt;
  core_stat_t stat_nxt;

  assign en_rise = core_en & ~en_q;
  assign active  = (st == ST_RUN) & core_en;

  always_comb begin
    st_nxt = st;
    if (!core_en)           st_nxt = ST_OFF;
    else if (en_rise)       st_nxt = ST_INIT;
    else if (st == ST_INIT) st_nxt = ST_RUN;
  end

  always_comb begin
    stat_nxt = stat;
    if (en_rise)                stat_nxt = boot_stat();
    else if (take)              stat_nxt = entry_stat(kind, stat);
    else if (active && ctl_we)  stat_nxt = ctl_stat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      st   <= ST_OFF;
      stat <= boot_stat();
    end else begin
      en_q <= core_en;
      st   <= st_nxt;
      stat <= stat_nxt;
    end
  end

  // R5: fast-interrupt entry masks both sources and switches mode.
  a_r5_fiq_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (take && kind == EXC_FIQ) |=> (stat.irq_off && stat.fiq_off && stat.mode == MODE_FIQ));

  // R11: status is frozen while the enable is low.
  a_r11_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |=> $stable(stat));

  // R2: the initialisation cycle always shows the boot status.
  a_r2_boot_status: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_INIT) |-> (stat == boot_stat()));

  // R2: initialisation lasts a single cycle.
  a_r2_init_short: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_INIT) |=> (st != ST_INIT));

endmodule

// File: rtl/exc_redirect.sv
module exc_redirect
  import exc_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] VEC_UND  = 32'h0000_0004,
  parameter logic [ADDR_W-1:0] VEC_SWI  = 32'h0000_0008,
  parameter logic [ADDR_W-1:0] VEC_FIQ  = 32'h0000_001C,
  parameter logic [ADDR_W-1:0] SP_USR   = 32'h0300_7F00,
  parameter logic [ADDR_W-1:0] SP_IRQ   = 32'h0300_7FA0,
  parameter logic [ADDR_W-1:0] SP_SVC   = 32'h0300_7FE0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              take,
  input  exc_kind_e         kind,
  input  logic [ADDR_W-1:0] next_pc,
  input  core_stat_t        old_stat,
  output logic              redirect,
  output logic [ADDR_W-1:0] pc_target,
  output logic              link_we,
  output logic [ADDR_W-1:0] link_val,
  output logic              saved_we,
  output logic [PSR_W-1:0]  saved_psr,
  output logic [1:0]        exc_code,
  output logic              init_pulse,
  output logic [ADDR_W-1:0] sp_usr_init,
  output logic [ADDR_W-1:0] sp_irq_init,
  output logic [ADDR_W-1:0] sp_svc_init
);

  localparam logic [ADDR_W-1:0] RET_OFS = ADDR_W'(4);

  function automatic logic [ADDR_W-1:0] vector_of(exc_kind_e k);
    case (k)
      EXC_UND: return VEC_UND;
      EXC_SWI: return VEC_SWI;
      EXC_FIQ: return VEC_FIQ;
      default: return RESET_PC;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] return_addr(logic [ADDR_W-1:0] npc);
    return npc + RET_OFS;
  endfunction

  logic              take_q;
  exc_kind_e         kind_q;
  logic [ADDR_W-1:0] vec_q;
  logic [ADDR_W-1:0] link_q;
  logic [PSR_W-1:0]  saved_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q  <= 1'b0;
      kind_q  <= EXC_NONE;
      vec_q   <= '0;
      link_q  <= '0;
      saved_q <= '0;
    end else begin
      take_q  <= take;
      kind_q  <= take ? kind : EXC_NONE;
      vec_q   <= take ? vector_of(kind) : '0;
      link_q  <= take ? return_addr(next_pc) : '0;
      saved_q <= take ? pack_stat(old_stat) : '0;
    end
  end

  assign redirect    = init | take_q;
  assign pc_target   = init ? RESET_PC : vec_q;
  assign link_we     = take_q;
  assign link_val    = link_q;
  assign saved_we    = take_q;
  assign saved_psr   = saved_q;
  assign exc_code    = kind_q;
  assign init_pulse  = init;
  assign sp_usr_init = init ? SP_USR : '0;
  assign sp_irq_init = init ? SP_IRQ : '0;
  assign sp_svc_init = init ? SP_SVC : '0;

  // R6: return address follows the next-instruction address of the accepting cycle.
  a_r6_link_addr: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (link_we && link_val == $past(next_pc) + ADDR_W'(4)));

  // R7: saved status word carries the pre-entry mode and masks.
  a_r7_saved_mode: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (saved_we && saved_psr[MODE_W-1:0] == $past(old_stat.mode)));

  // R2: an initialisation cycle writes no link register.
  a_r2_init_no_link: assert property (@(posedge clk) disable iff (!rst_n)
    init |-> !take_q);

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] VEC_UND  = 32'h0000_0004,
  parameter logic [ADDR_W-1:0] VEC_SWI  = 32'h0000_0008,
  parameter logic [ADDR_W-1:0] VEC_FIQ  = 32'h0000_001C,
  parameter logic [ADDR_W-1:0] SP_USR   = 32'h0300_7F00,
  parameter logic [ADDR_W-1:0] SP_IRQ   = 32'h0300_7FA0,
  parameter logic [ADDR_W-1:0] SP_SVC   = 32'h0300_7FE0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_en,
  input  logic              fetch_slot,
  input  logic              swi_req,
  input  logic              und_req,
  input  logic              fiq_req,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic              ctl_we,
  input  logic [4:0]        ctl_mode,
  input  logic              ctl_irq_off,
  input  logic              ctl_fiq_off,
  output logic              running,
  output logic [4:0]        cur_mode,
  output logic              irq_off,
  output logic              fiq_off,
  output logic              fiq_pend,
  output logic              redirect,
  output logic [ADDR_W-1:0] pc_target,
  output logic              link_we,
  output logic [ADDR_W-1:0] link_val,
  output logic              saved_we,
  output logic [31:0]       saved_psr,
  output logic [1:0]        exc_code,
  output logic              init_pulse,
  output logic [ADDR_W-1:0] sp_usr_init,
  output logic [ADDR_W-1:0] sp_irq_init,
  output logic [ADDR_W-1:0] sp_svc_init
);

  core_stat_t stat;
  core_stat_t ctl_stat;
  run_st_e    st;
  logic       active;
  logic       take;
  exc_kind_e  kind;
  logic       in_init;

  assign ctl_stat.mode    = ctl_mode;
  assign ctl_stat.irq_off = ctl_irq_off;
  assign ctl_stat.fiq_off = ctl_fiq_off;

  // Pending fast interrupt follows the mask with no register in the path.
  assign fiq_pend = fiq_req & ~stat.fiq_off;
  assign in_init  = (st == ST_INIT);

  exc_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .fetch_slot (fetch_slot),
    .fiq_pend   (fiq_pend),
    .und_req    (und_req),
    .swi_req    (swi_req),
    .take       (take),
    .kind       (kind)
  );

  exc_state u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .core_en  (core_en),
    .take     (take),
    .kind     (kind),
    .ctl_we   (ctl_we),
    .ctl_stat (ctl_stat),
    .stat     (stat),
    .st       (st),
    .active   (active)
  );

  exc_redirect #(
    .ADDR_W   (ADDR_W),
    .RESET_PC (RESET_PC),
    .VEC_UND  (VEC_UND),
    .VEC_SWI  (VEC_SWI),
    .VEC_FIQ  (VEC_FIQ),
    .SP_USR   (SP_USR),
    .SP_IRQ   (SP_IRQ),
    .SP_SVC   (SP_SVC)
  ) u_redir (
    .clk         (clk),
    .rst_n       (rst_n),
    .init        (in_init),
    .take        (take),
    .kind        (kind),
    .next_pc     (next_pc),
    .old_stat    (stat),
    .redirect    (redirect),
    .pc_target   (pc_target),
    .link_we     (link_we),
    .link_val    (link_val),
    .saved_we    (saved_we),
    .saved_psr   (saved_psr),
    .exc_code    (exc_code),
    .init_pulse  (init_pulse),
    .sp_usr_init (sp_usr_init),
    .sp_irq_init (sp_irq_init),
    .sp_svc_init (sp_svc_init)
  );

  assign running  = (st == ST_RUN);
  assign cur_mode = stat.mode;
  assign irq_off  = stat.irq_off;
  assign fiq_off  = stat.fiq_off;

  // R5: a fast-interrupt redirect follows an instruction-boundary cycle.
  a_r5_fiq_at_slot: assert property (@(posedge clk) disable iff (!rst_n)
    take && kind == EXC_FIQ |=> (redirect && exc_code == 2'd3 && $past(fetch_slot)));

  // R3: software-interrupt entry lands in supervisor mode with normal interrupts masked.
  a_r3_swi_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (take && kind == EXC_SWI) |=> (cur_mode == MODE_SVC && irq_off && fiq_off == $past(fiq_off)));

  // R4: undefined entry keeps the fast mask and masks normal interrupts.
  a_r4_und_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (take && kind == EXC_UND) |=> (cur_mode == MODE_UND && irq_off && fiq_off == $past(fiq_off)));

  // R8: once the fast mask is set, nothing can be pending.
  a_r8_pend_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (take && kind == EXC_FIQ) |=> !fiq_pend);

endmodule

// File: tb/exc_entry_seq_test.sv
`timescale 1ns/1ps
module exc_entry_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_en = 1'b0, fetch_slot = 1'b0, swi_req = 1'b0, und_req = 1'b0, fiq_req = 1'b0;
  logic [31:0] next_pc = '0;
  logic        ctl_we = 1'b0;
  logic [4:0]  ctl_mode = '0;
  logic        ctl_irq_off = 1'b0, ctl_fiq_off = 1'b0;
  logic        running, irq_off, fiq_off, fiq_pend, redirect, link_we, saved_we, init_pulse;
  logic [4:0]  cur_mode;
  logic [31:0] pc_target, link_val, saved_psr, sp_usr_init, sp_irq_init, sp_svc_init;
  logic [1:0]  exc_code;

  always #2.5 clk = ~clk;

  exc_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .core_en(core_en), .fetch_slot(fetch_slot),
    .swi_req(swi_req), .und_req(und_req), .fiq_req(fiq_req), .next_pc(next_pc),
    .ctl_we(ctl_we), .ctl_mode(ctl_mode), .ctl_irq_off(ctl_irq_off), .ctl_fiq_off(ctl_fiq_off),
    .running(running), .cur_mode(cur_mode), .irq_off(irq_off), .fiq_off(fiq_off),
    .fiq_pend(fiq_pend), .redirect(redirect), .pc_target(pc_target), .link_we(link_we),
    .link_val(link_val), .saved_we(saved_we), .saved_psr(saved_psr), .exc_code(exc_code),
    .init_pulse(init_pulse), .sp_usr_init(sp_usr_init), .sp_irq_init(sp_irq_init),
    .sp_svc_init(sp_svc_init)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Bench model of the requirement-level state.
  logic [4:0] m_mode = 5'h13;
  logic       m_irq = 1'b0, m_fiq = 1'b1, m_enq = 1'b0;
  int         m_st = 0; // 0 off, 1 init, 2 run

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] f_vec(input int k);
    case (k)
      1: return 32'h08;
      2: return 32'h04;
      3: return 32'h1C;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] f_word(input logic [4:0] md, input logic i, input logic f);
    return {24'h0, i, f, 1'b0, md};
  endfunction

  task automatic step(input logic en, input logic fs, input logic sw, input logic un,
                      input logic fq, input logic [31:0] npc, input logic cw,
                      input logic [4:0] cm, input logic ci, input logic cf);
    logic pend, e_init, run_now, t_f, t_u, t_s, take;
    int   kind, n_st, nsrc;
    string t;
    logic [4:0] n_mode;
    logic n_irq, n_fiq;
    @(negedge clk);
    core_en = en; fetch_slot = fs; swi_req = sw; und_req = un; fiq_req = fq;
    next_pc = npc; ctl_we = cw; ctl_mode = cm; ctl_irq_off = ci; ctl_fiq_off = cf;
    #1;
    pend = fq & ~m_fiq;
    chk("R8 fiq_pend", {31'h0, fiq_pend}, {31'h0, pend});
    e_init  = en & ~m_enq;
    run_now = (m_st == 2) && en;
    t_f = run_now & fs & pend;
    t_u = run_now & un & ~t_f;
    t_s = run_now & sw & ~t_f & ~un;
    take = t_f | t_u | t_s;
    kind = t_f ? 3 : t_u ? 2 : t_s ? 1 : 0;
    nsrc = int'(fs & pend) + int'(un) + int'(sw);
    n_st = !en ? 0 : e_init ? 1 : (m_st == 1) ? 2 : m_st;
    n_mode = m_mode; n_irq = m_irq; n_fiq = m_fiq;
    if (e_init) begin n_mode = 5'h13; n_irq = 1'b0; n_fiq = 1'b1; end
    else if (t_f) begin n_mode = 5'h11; n_irq = 1'b1; n_fiq = 1'b1; end
    else if (t_u) begin n_mode = 5'h1B; n_irq = 1'b1; end
    else if (t_s) begin n_mode = 5'h13; n_irq = 1'b1; end
    else if (run_now && cw) begin n_mode = cm; n_irq = ci; n_fiq = cf; end
    if (take && nsrc > 1) t = "R9";
    else if (t_f) t = "R5";
    else if (t_u) t = "R4";
    else if (t_s) t = "R3";
    else if (e_init) t = "R2";
    else if (!run_now) t = "R11";
    else t = "R10";
    @(posedge clk);
    #1;
    chk({t, " redirect"}, {31'h0, redirect}, {31'h0, (e_init | take)});
    chk({t, " mode"}, {27'h0, cur_mode}, {27'h0, n_mode});
    chk({t, " irq_off"}, {31'h0, irq_off}, {31'h0, n_irq});
    chk({t, " fiq_off"}, {31'h0, fiq_off}, {31'h0, n_fiq});
    chk({t, " exc_code"}, {30'h0, exc_code}, kind);
    chk("R2 running", {31'h0, running}, {31'h0, (n_st == 2)});
    chk("R2 init_pulse", {31'h0, init_pulse}, {31'h0, e_init});
    chk("R2 sp_usr", sp_usr_init, e_init ? 32'h0300_7F00 : 32'h0);
    chk("R2 sp_irq", sp_irq_init, e_init ? 32'h0300_7FA0 : 32'h0);
    chk("R2 sp_svc", sp_svc_init, e_init ? 32'h0300_7FE0 : 32'h0);
    if (e_init | take) chk({t, " pc_target"}, pc_target, f_vec(kind));
    chk("R6 link_we", {31'h0, link_we}, {31'h0, take});
    chk("R7 saved_we", {31'h0, saved_we}, {31'h0, take});
    if (take) begin
      chk("R6 link_val", link_val, npc + 32'd4);
      chk("R7 saved_psr", saved_psr, f_word(m_mode, m_irq, m_fiq));
    end
    m_mode = n_mode; m_irq = n_irq; m_fiq = n_fiq; m_enq = en; m_st = n_st;
  endtask

  task automatic idle(input logic en);
    step(en, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 5'h0, 1'b0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 mode", {27'h0, cur_mode}, 32'h13);
    chk("R1 irq_off", {31'h0, irq_off}, 32'h0);
    chk("R1 fiq_off", {31'h0, fiq_off}, 32'h1);
    chk("R1 running", {31'h0, running}, 32'h0);
    chk("R1 redirect", {31'h0, redirect}, 32'h0);

    // R11: requests while disabled
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h100, 1'b1, 5'h10, 1'b1, 1'b0);
    // R2: enable rise, then run
    idle(1'b1);
    idle(1'b1);
    // R8: unmask fast interrupt via control write (R10), then pending right away
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0, 1'b1, 5'h10, 1'b0, 1'b0);
    // R5: line high without an instruction boundary is not taken
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h200, 1'b0, 5'h0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h204, 1'b0, 5'h0, 1'b0, 1'b0);
    // R3 and R10: software interrupt with a control write in the same cycle
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h300, 1'b1, 5'h10, 1'b0, 1'b0);
    // R4 with link wrap (R6)
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFC, 1'b0, 5'h0, 1'b0, 1'b0);
    // R9: all three together, after unmasking
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 5'h10, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 32'h400, 1'b0, 5'h0, 1'b0, 1'b0);
    // R9: undefined beats software interrupt
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h500, 1'b0, 5'h0, 1'b0, 1'b0);
    // R2: disable and re-enable restarts initialisation
    idle(1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h600, 1'b1, 5'h1F, 1'b1, 1'b1);
    idle(1'b1);
    idle(1'b1);

    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic en, fs, sw, un, fq, cw, ci, cf;
      logic [4:0] cm;
      en = ($urandom % 40) != 0;
      fs = ($urandom % 3) == 0;
      sw = ($urandom % 8) == 0;
      un = ($urandom % 10) == 0;
      fq = ($urandom % 4) == 0;
      cw = ($urandom % 6) == 0;
      cm = ($urandom % 2) ? 5'h10 : 5'h1F;
      ci = $urandom % 2;
      cf = ($urandom % 3) == 0;
      step(en, fs, sw, un, fq, $urandom, cw, cm, ci, cf);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule